// File: doc/BRIEF.md
# Image Sensor Control Sequencer

This block brings up a camera sensor for a slow host and manages its power afterwards. The host fills a sixteen-entry, eight-bit configuration file through a small write port. The file holds the sensor's device address, a register/value pair that sends the sensor to sleep, a pair that wakes it, up to four setup pairs with a count of how many to use, and two frame-geometry bytes that are passed straight out to the read-address logic.

An init request pulls the sensor's reset line low, releases it, and then waits for the sensor to settle. The sequencer then sends the setup writes and the wake write one at a time to a serial write master through a start/done handshake. When the capture path reports a complete frame, the sequencer sends the sleep write. Each later rising edge of the frame request wakes the sensor again for the next frame, with the same configuration. A host reset pulse returns the sequencer to idle at any point.

Top module: `sensor_ctl_seq`

## Requirements
- R1: A write strobe stores the data byte at the addressed entry. Entry 14 (width over four) and entry 15 (bytes per pixel) appear on `width_q4_o` and `bpp_o`. All entries reset to zero.
- R2: One cycle after an init request is sampled in idle, `sensor_rst_no` goes low. It stays low for exactly `RST_LOW` (16) cycles and is high at all other times.
- R3: The first command start comes exactly `WAIT_CYCLES` (2000) cycles after the cycle in which `sensor_rst_no` first went low.
- R4: The setup commands go out in index order. Command k (k = 0..3) carries register address entry 6+2k and data entry 7+2k. The number sent is entry 1 clamped to 4.
- R5: When entry 1 is zero, the first command after the wait is the wake command.
- R6: The last setup command is followed by the wake command, which carries entries 4 (address) and 5 (data). Every command carries entry 0 as the device address.
- R7: Frame-received, while the sequencer awaits a frame, starts the sleep command, which carries entries 2 (address) and 3 (data).
- R8: After the sleep command completes, a rising edge of `req_frame_i` starts a new wake command. A level held high does not start another one, and a frame request in any other state has no effect.
- R9: `cmd_start_o` is a one-cycle pulse. No new start occurs until `cmd_done_i` has answered the previous one.
- R10: A `cmd_done_i` with `cmd_nack_i` high sets `err_o`. The flag stays set until a host reset.
- R11: A cycle with `host_rst_i` high returns the sequencer to idle and clears `err_o`. No further command starts, and the reset line stays high, until a new init request.
- R12: An init request outside idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_rst_i | input | 1 | Host reset, synchronous, returns to idle |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration entry index |
| cfg_data_i | input | 8 | Configuration write data |
| init_i | input | 1 | Start full bring-up from idle |
| req_frame_i | input | 1 | Frame request, rising edge wakes sensor |
| frame_rcvd_i | input | 1 | Full frame stored by capture path |
| cmd_start_o | output | 1 | One-cycle start to the serial write master |
| cmd_dev_o | output | 8 | Device address of the current command |
| cmd_reg_o | output | 8 | Sensor register address of the current command |
| cmd_dat_o | output | 8 | Data byte of the current command |
| cmd_done_i | input | 1 | Serial write master finished |
| cmd_nack_i | input | 1 | Not-acknowledge reported with done |
| err_o | output | 1 | Sticky not-acknowledge flag |
| sensor_rst_no | output | 1 | Active-low sensor reset |
| width_q4_o | output | 8 | Stored image width divided by four |
| bpp_o | output | 8 | Stored bytes per pixel |

## Verification
The bench measures the reset pulse length and the gap to the first start to the cycle. An off-by-one counter shifts either value by one. It programs a command count above four and a count of zero: a missing clamp sends commands made from the geometry entries, and a missing skip issues a bogus setup before wake. It holds the frame request high across a full sleep and also pulses it and init in the wrong states. A level-triggered design or one that does not gate by state emits extra wake or reset activity. A not-acknowledge followed by a clean command shows whether the error flag is truly sticky, and a host reset during the settle wait shows whether a leftover counter still fires a command.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RST_WAIT, ST_SETUP, ST_WAKE, ST_WAIT_FRAME, ST_SLEEP, ST_WAIT_REQ
  } seq_state_e;

  typedef enum logic [1:0] {CK_NONE, CK_SETUP, CK_WAKE, CK_SLEEP} cmd_kind_e;

  localparam int unsigned IdxDev    = 0;
  localparam int unsigned IdxNcmd   = 1;
  localparam int unsigned IdxSlpA   = 2;
  localparam int unsigned IdxSlpD   = 3;
  localparam int unsigned IdxWakA   = 4;
  localparam int unsigned IdxWakD   = 5;
  localparam int unsigned IdxSetup0 = 6;
  localparam int unsigned IdxWidth  = 14;
  localparam int unsigned IdxBpp    = 15;
endpackage

// File: rtl/sseq_regfile.sv
module sseq_regfile #(
  parameter int unsigned AW       = 4,
  parameter int unsigned DW       = 8,
  parameter int unsigned MAX_CMDS = 4,
  localparam int unsigned NREG    = 2 ** AW,
  localparam int unsigned CW      = $clog2(MAX_CMDS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             data_i,
  output logic [NREG-1:0][DW-1:0]   regs_o,
  output logic [CW-1:0]             n_cmds_o
);
  import sseq_pkg::*;

  logic [NREG-1:0][DW-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= '0;
    else if (wr_i) regs_q[addr_i] <= data_i;
  end

  assign regs_o = regs_q;

  // clamp programmed count to the number of setup slots
  always_comb begin
    if (regs_q[IdxNcmd] > DW'(MAX_CMDS)) n_cmds_o = CW'(MAX_CMDS);
    else                                n_cmds_o = regs_q[IdxNcmd][CW-1:0];
  end
endmodule

// File: rtl/sseq_wait_timer.sv
module sseq_wait_timer #(
  parameter int unsigned WAIT_CYCLES = 2000,
  parameter int unsigned RST_LOW     = 16,
  localparam int unsigned TW         = $clog2(WAIT_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  output logic expired_o,
  output logic hold_o
);
  localparam logic [TW-1:0] LoadVal = TW'(WAIT_CYCLES - 1);
  localparam logic [TW-1:0] HoldLim = TW'(WAIT_CYCLES - 1 - RST_LOW);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= LoadVal;
    else if (en_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
  assign hold_o    = (cnt_q > HoldLim);
endmodule

// File: rtl/sseq_cmd_sel.sv
module sseq_cmd_sel #(
  parameter int unsigned DW       = 8,
  parameter int unsigned NREG     = 16,
  parameter int unsigned MAX_CMDS = 4,
  localparam int unsigned IW      = (MAX_CMDS > 1) ? $clog2(MAX_CMDS) : 1
) (
  input  logic [NREG-1:0][DW-1:0] regs_i,
  input  sseq_pkg::cmd_kind_e     kind_i,
  input  logic [IW-1:0]           idx_i,
  output logic [DW-1:0]           dev_o,
  output logic [DW-1:0]           reg_o,
  output logic [DW-1:0]           dat_o
);
  import sseq_pkg::*;

  logic [MAX_CMDS-1:0][DW-1:0] su_a, su_d;

  for (genvar k = 0; k < MAX_CMDS; k++) begin : g_setup
    assign su_a[k] = regs_i[IdxSetup0 + 2*k];
    assign su_d[k] = regs_i[IdxSetup0 + 2*k + 1];
  end

  always_comb begin
    dev_o = regs_i[IdxDev];
    reg_o = '0;
    dat_o = '0;
    unique case (kind_i)
      CK_SETUP: begin reg_o = su_a[idx_i]; dat_o = su_d[idx_i]; end
      CK_WAKE:  begin reg_o = regs_i[IdxWakA]; dat_o = regs_i[IdxWakD]; end
      CK_SLEEP: begin reg_o = regs_i[IdxSlpA]; dat_o = regs_i[IdxSlpD]; end
      default:  dev_o = '0;
    endcase
  end
endmodule

// File: rtl/sseq_fsm.sv
module sseq_fsm #(
  parameter int unsigned MAX_CMDS = 4,
  localparam int unsigned CW      = $clog2(MAX_CMDS + 1),
  localparam int unsigned IW      = (MAX_CMDS > 1) ? $clog2(MAX_CMDS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 host_rst_i,
  input  logic                 init_i,
  input  logic                 req_frame_i,
  input  logic                 frame_rcvd_i,
  input  logic                 cmd_done_i,
  input  logic                 cmd_nack_i,
  input  logic [CW-1:0]        n_cmds_i,
  input  logic                 tmr_expired_i,
  input  logic                 tmr_hold_i,
  output logic                 tmr_load_o,
  output logic                 tmr_en_o,
  output sseq_pkg::cmd_kind_e  kind_o,
  output logic [IW-1:0]        idx_o,
  output logic                 cmd_start_o,
  output logic                 sensor_rst_no,
  output logic                 err_o
);
  import sseq_pkg::*;

  seq_state_e    st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          issued_q, req_q, err_q;
  logic          in_cmd, done_ok, req_rise, last_setup;

  assign in_cmd     = (st_q == ST_SETUP) || (st_q == ST_WAKE) || (st_q == ST_SLEEP);
  assign done_ok    = in_cmd && issued_q && cmd_done_i;
  assign req_rise   = req_frame_i && !req_q;
  assign last_setup = (CW'(idx_q) + CW'(1)) >= n_cmds_i;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    if (host_rst_i) begin
      st_d  = ST_IDLE;
      idx_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE:     if (init_i) st_d = ST_RST_WAIT;
        ST_RST_WAIT: if (tmr_expired_i) begin
          idx_d = '0;
          st_d  = (n_cmds_i == '0) ? ST_WAKE : ST_SETUP;
        end
        ST_SETUP: if (done_ok) begin
          if (last_setup) begin st_d = ST_WAKE; idx_d = '0; end
          else idx_d = idx_q + 1'b1;
        end
        ST_WAKE:       if (done_ok) st_d = ST_WAIT_FRAME;
        ST_WAIT_FRAME: if (frame_rcvd_i) st_d = ST_SLEEP;
        ST_SLEEP:      if (done_ok) st_d = ST_WAIT_REQ;
        ST_WAIT_REQ:   if (req_rise) st_d = ST_WAKE;
        default:       st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      issued_q <= 1'b0;
      req_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      req_q <= req_frame_i;
      if (host_rst_i || done_ok) issued_q <= 1'b0;
      else if (cmd_start_o)      issued_q <= 1'b1;
      if (host_rst_i)                 err_q <= 1'b0;
      else if (done_ok && cmd_nack_i) err_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_SETUP: kind_o = CK_SETUP;
      ST_WAKE:  kind_o = CK_WAKE;
      ST_SLEEP: kind_o = CK_SLEEP;
      default:  kind_o = CK_NONE;
    endcase
  end

  assign idx_o         = idx_q;
  assign cmd_start_o   = in_cmd && !issued_q && !host_rst_i;
  assign tmr_load_o    = (st_q == ST_IDLE) && init_i && !host_rst_i;
  assign tmr_en_o      = (st_q == ST_RST_WAIT);
  assign sensor_rst_no = !((st_q == ST_RST_WAIT) && tmr_hold_i);
  assign err_o         = err_q;
endmodule

// File: rtl/sensor_ctl_seq.sv
module sensor_ctl_seq #(
  parameter int unsigned AW          = 4,
  parameter int unsigned DW          = 8,
  parameter int unsigned MAX_CMDS    = 4,
  parameter int unsigned WAIT_CYCLES = 2000,
  parameter int unsigned RST_LOW     = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_rst_i,
  input  logic          cfg_wr_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [DW-1:0] cfg_data_i,
  input  logic          init_i,
  input  logic          req_frame_i,
  input  logic          frame_rcvd_i,
  output logic          cmd_start_o,
  output logic [DW-1:0] cmd_dev_o,
  output logic [DW-1:0] cmd_reg_o,
  output logic [DW-1:0] cmd_dat_o,
  input  logic          cmd_done_i,
  input  logic          cmd_nack_i,
  output logic          err_o,
  output logic          sensor_rst_no,
  output logic [DW-1:0] width_q4_o,
  output logic [DW-1:0] bpp_o
);
  import sseq_pkg::*;

  localparam int unsigned NREG = 2 ** AW;
  localparam int unsigned CW   = $clog2(MAX_CMDS + 1);
  localparam int unsigned IW   = (MAX_CMDS > 1) ? $clog2(MAX_CMDS) : 1;

  logic [NREG-1:0][DW-1:0] regs;
  logic [CW-1:0]           n_cmds;
  logic                    tmr_load, tmr_en, tmr_expired, tmr_hold;
  cmd_kind_e               kind;
  logic [IW-1:0]           idx;

  sseq_regfile #(.AW(AW), .DW(DW), .MAX_CMDS(MAX_CMDS)) u_regs (
    .clk_i, .rst_ni, .wr_i(cfg_wr_i), .addr_i(cfg_addr_i), .data_i(cfg_data_i),
    .regs_o(regs), .n_cmds_o(n_cmds)
  );

  sseq_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES), .RST_LOW(RST_LOW)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .en_i(tmr_en),
    .expired_o(tmr_expired), .hold_o(tmr_hold)
  );

  sseq_fsm #(.MAX_CMDS(MAX_CMDS)) u_fsm (
    .clk_i, .rst_ni, .host_rst_i, .init_i, .req_frame_i, .frame_rcvd_i,
    .cmd_done_i, .cmd_nack_i, .n_cmds_i(n_cmds),
    .tmr_expired_i(tmr_expired), .tmr_hold_i(tmr_hold),
    .tmr_load_o(tmr_load), .tmr_en_o(tmr_en), .kind_o(kind), .idx_o(idx),
    .cmd_start_o, .sensor_rst_no, .err_o
  );

  sseq_cmd_sel #(.DW(DW), .NREG(NREG), .MAX_CMDS(MAX_CMDS)) u_sel (
    .regs_i(regs), .kind_i(kind), .idx_i(idx),
    .dev_o(cmd_dev_o), .reg_o(cmd_reg_o), .dat_o(cmd_dat_o)
  );

  assign width_q4_o = regs[IdxWidth];
  assign bpp_o      = regs[IdxBpp];
endmodule

// File: rtl/sensor_ctl_seq_chk.sv
module sensor_ctl_seq_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          host_rst_i,
  input logic          init_i,
  input logic          cmd_start_o,
  input logic [DW-1:0] cmd_reg_o,
  input logic [DW-1:0] cmd_dat_o,
  input logic          cmd_done_i,
  input logic          cmd_nack_i,
  input logic          err_o,
  input logic          sensor_rst_no
);
  // R9
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_start_o |=> !cmd_start_o);

  // R4
  cmd_fields_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_start_o && !host_rst_i) |=> ($stable(cmd_reg_o) && $stable(cmd_dat_o)));

  // R2
  rst_after_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sensor_rst_no) |-> $past(init_i));

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !host_rst_i) |=> err_o);

  // R10
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(cmd_done_i && cmd_nack_i));

  // R11
  host_rst_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rst_i |=> (!cmd_start_o && sensor_rst_no && !err_o));
endmodule

bind sensor_ctl_seq sensor_ctl_seq_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_rst_i(host_rst_i), .init_i(init_i),
  .cmd_start_o(cmd_start_o), .cmd_reg_o(cmd_reg_o), .cmd_dat_o(cmd_dat_o),
  .cmd_done_i(cmd_done_i), .cmd_nack_i(cmd_nack_i), .err_o(err_o),
  .sensor_rst_no(sensor_rst_no)
);

// File: tb/sensor_ctl_seq_tb.sv
module sensor_ctl_seq_tb;
  localparam int W = 2000;

  logic clk = 0, rst_ni = 0, host_rst = 0, cfg_wr = 0, init = 0, req = 0, frm = 0;
  logic [3:0] cfg_addr = 0;
  logic [7:0] cfg_data = 0;
  logic done = 0, nack = 0, nack_en = 0;
  logic cmd_start, err, srst_n;
  logic [7:0] dev, creg, cdat, width_q4, bpp;

  int checks = 0, errors = 0, cyc = 0;
  int log_n = 0, r9_bad = 0, low_cnt = 0, fall_cyc = 0;
  logic [7:0] log_dev [64];
  logic [7:0] log_reg [64];
  logic [7:0] log_dat [64];
  int         log_cyc [64];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sensor_ctl_seq u_dut (
    .clk_i(clk), .rst_ni, .host_rst_i(host_rst), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
    .cfg_data_i(cfg_data), .init_i(init), .req_frame_i(req), .frame_rcvd_i(frm),
    .cmd_start_o(cmd_start), .cmd_dev_o(dev), .cmd_reg_o(creg), .cmd_dat_o(cdat),
    .cmd_done_i(done), .cmd_nack_i(nack), .err_o(err), .sensor_rst_no(srst_n),
    .width_q4_o(width_q4), .bpp_o(bpp)
  );

  // {addr, data}
  localparam logic [11:0] CFG_TBL [16] = '{
    12'h03C, 12'h103, 12'h209, 12'h301, 12'h409, 12'h500, 12'h610, 12'h7A1,
    12'h811, 12'h9A2, 12'hA12, 12'hBA3, 12'hC13, 12'hDA4, 12'hE28, 12'hF02};
  // {reg, data} of the first bring-up: three setups then wake
  localparam logic [15:0] EXP_CMD [4] = '{16'h10A1, 16'h11A2, 16'h12A3, 16'h0900};

  task automatic chk(string req_s, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req_s, act, exp);
    end
  endtask

  // serial master model, also watches start spacing
  initial begin
    forever begin
      @(negedge clk);
      while (cmd_start) begin
        if (log_n < 64) begin
          log_dev[log_n] = dev; log_reg[log_n] = creg;
          log_dat[log_n] = cdat; log_cyc[log_n] = cyc;
        end
        log_n++;
        repeat (3) begin
          @(negedge clk);
          if (cmd_start) r9_bad++;
        end
        done = 1; nack = nack_en;
        @(negedge clk);
        done = 0; nack = 0;
      end
    end
  end

  // sensor reset monitor
  initial begin
    logic prev = 1;
    forever begin
      @(negedge clk);
      if (!srst_n) low_cnt++;
      if (prev && !srst_n) fall_cyc = cyc;
      prev = srst_n;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic wr_cfg(logic [3:0] a, logic [7:0] d);
    @(negedge clk); cfg_addr = a; cfg_data = d; cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic pulse_init();
    @(negedge clk); init = 1; @(negedge clk); init = 0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frm = 1; @(negedge clk); frm = 0;
  endtask

  task automatic pulse_host_rst();
    @(negedge clk); host_rst = 1; @(negedge clk); host_rst = 0;
  endtask

  task automatic wait_log(int n, string req_s);
    int t = 0;
    while (log_n < n && t < 6000) begin @(negedge clk); t++; end
    chk(req_s, log_n, n);
    repeat (6) @(negedge clk);
  endtask

  task automatic chk_cmd(int i, string req_s, logic [7:0] a, logic [7:0] d);
    chk(req_s, {log_dev[i], log_reg[i], log_dat[i]}, {8'h3C, a, d});
  endtask

  initial begin
    int base, lows, fcyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset width", width_q4, 0);
    chk("R1 reset bpp", bpp, 0);
    chk("R2 reset line idle", srst_n, 1);
    chk("R10 err at reset", err, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 16; i++) wr_cfg(CFG_TBL[i][11:8], CFG_TBL[i][7:0]);
    chk("R1 width", width_q4, 8'h28);
    chk("R1 bpp", bpp, 8'h02);

    // first bring-up
    lows = low_cnt;
    pulse_init();
    wait_log(4, "R6 bring-up count");
    chk("R2 low cycles", low_cnt - lows, 16);
    fcyc = fall_cyc;
    chk("R3 wait length", log_cyc[0] - fcyc, W);
    for (int i = 0; i < 4; i++)
      chk_cmd(i, (i < 3) ? "R4 setup cmd" : "R6 wake cmd", EXP_CMD[i][15:8], EXP_CMD[i][7:0]);

    // wrong-state stimulus while awaiting frame
    lows = low_cnt;
    pulse_init();
    @(negedge clk); req = 1; @(negedge clk); req = 0;
    repeat (30) @(negedge clk);
    chk("R12 init ignored", low_cnt - lows, 0);
    chk("R8 req ignored awaiting frame", log_n, 4);

    pulse_frame();
    wait_log(5, "R7 sleep issued");
    chk_cmd(4, "R7 sleep cmd", 8'h09, 8'h01);

    // held request: one wake only
    @(negedge clk); req = 1;
    wait_log(6, "R8 wake on rise");
    chk_cmd(5, "R8 wake cmd", 8'h09, 8'h00);
    pulse_frame();
    wait_log(7, "R7 second sleep");
    repeat (30) @(negedge clk);
    chk("R8 level no retrigger", log_n, 7);
    @(negedge clk); req = 0; @(negedge clk); req = 1;
    wait_log(8, "R8 wake after new rise");
    @(negedge clk); req = 0;

    // not-acknowledge
    nack_en = 1;
    pulse_frame();
    wait_log(9, "R10 nack cmd");
    nack_en = 0;
    chk("R10 err set", err, 1);
    @(negedge clk); req = 1; @(negedge clk); req = 0;
    wait_log(10, "R10 clean wake");
    chk("R10 err sticky", err, 1);

    // host reset during settle wait
    pulse_host_rst();
    chk("R11 err cleared", err, 0);
    base = log_n;
    pulse_init();
    repeat (100) @(negedge clk);
    pulse_host_rst();
    repeat (W + 100) @(negedge clk);
    chk("R11 no command after reset", log_n, base);
    chk("R11 line released", srst_n, 1);

    // clamp: count 7 -> 4 commands then wake
    wr_cfg(4'h1, 8'h07);
    base = log_n;
    pulse_init();
    wait_log(base + 5, "R4 clamp count");
    for (int k = 0; k < 4; k++) chk_cmd(base + k, "R4 clamp order", 8'h10 + 8'(k), 8'hA1 + 8'(k));
    chk_cmd(base + 4, "R4 wake after four", 8'h09, 8'h00);
    repeat (20) @(negedge clk);
    chk("R4 no fifth setup", log_n, base + 5);

    // zero count skips to wake
    pulse_host_rst();
    wr_cfg(4'h1, 8'h00);
    base = log_n;
    pulse_init();
    wait_log(base + 1, "R5 single command");
    chk_cmd(base, "R5 wake first", 8'h09, 8'h00);

    chk("R9 start spacing", r9_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule